// File: doc/BRIEF.md
# Signed-Count Reversing Barrel Shifter

This unit shifts one operand per cycle for a DSP datapath. It handles either a 16-bit half-word or a 40-bit accumulator. The shift amount comes as a two's-complement count, and its sign picks the direction. When the count is non-negative, the unit performs the operation the opcode asks for. When the count is negative, the unit performs the opposite operation, by the magnitude of the count: a logical left shift becomes an arithmetic right shift, and the reverse. Accumulator shifts run through a rotating barrel stage, so a magnitude past 32 wraps back into range instead of clamping.

The datapath is combinational. Its result, its zero flag and its overflow flag are captured in one register stage. They appear with `out_valid` on the clock edge that follows an accepted `in_valid`. Between operations the outputs hold their last values.

Top module: `bshift_unit`

## Requirements
- R1: `in_op` encodes the operation. Bit 1 set selects the 40-bit accumulator and bit 1 clear selects the half-word. Bit 0 set requests an arithmetic right shift and bit 0 clear requests a logical left shift. In half-word mode only `in_count[4:0]` is used, read as a signed value, and `in_count[6:5]` has no effect.
- R2: In half-word mode, a count from 0 to 15 performs the requested operation by that many bits.
- R3: In half-word mode, a count from -16 to -1 performs the opposite operation by the negated count, which is 1 to 16 bits.
- R4: In accumulator mode, `in_count[6:0]` is signed. A non-negative count performs the requested operation, and a negative count performs the opposite operation by its magnitude.
- R5: In accumulator mode, a magnitude greater than 32 wraps to the magnitude minus 32.
- R6: Left shifts fill the vacated low bits with zeros. Arithmetic right shifts fill the vacated high bits with the operand's sign bit. A shift of the full width leaves all zeros (left) or all sign bits (right).
- R7: `out_ovf` is set after a left shift when any bit shifted out, or the new sign bit, differs from the original sign bit. It is clear after every right shift, in both modes.
- R8: `out_zero` is set exactly when the final result, after any wrap and reversal, is zero.
- R9: A half-word result occupies `out_result[15:0]` and `out_result[39:16]` reads zero. `in_data[39:16]` has no effect in half-word mode.
- R10: The result and both flags appear with `out_valid` one clock after `in_valid`. While `in_valid` is low, `out_valid` is low and the result and flags hold their values.
- R11: A synchronous active-high `rst` clears `out_valid`, `out_result`, `out_zero` and `out_ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 2 | Bit 1: accumulator mode; bit 0: arithmetic right requested |
| in_data | input | 40 | Operand; the half-word uses bits 15:0 |
| in_count | input | 7 | Signed shift count |
| out_valid | output | 1 | Result registered this cycle |
| out_result | output | 40 | Shifted value |
| out_zero | output | 1 | Result is zero |
| out_ovf | output | 1 | Left shift lost significant bits |

## Verification
The zero flag and the overflow flag can both rise in the same cycle. This happens when a left shift pushes every set bit out of a non-zero operand. The bench provokes the case through a reversed half-word right shift with count -16, and through an accumulator count that wraps to 32. In both cases the bench expects `out_zero` and `out_ovf` to be set together. Direction reversal and count wrap can also act on the same operation, for example an accumulator right shift with count -64. The bench judges such results against its own wide-integer reference.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  localparam int ACC_W   = 40;
  localparam int HALF_W  = 16;
  localparam int CNT_W   = 7;
  localparam int HCNT_W  = 5;
  localparam int WRAP_AT = 32;

  typedef enum logic [1:0] {
    OP_HALF_LSL = 2'b00,
    OP_HALF_ASR = 2'b01,
    OP_ACC_LSL  = 2'b10,
    OP_ACC_ASR  = 2'b11
  } shop_e;

  typedef struct packed {
    logic [ACC_W-1:0] result;
    logic             zero;
    logic             ovf;
  } shres_t;
endpackage

// File: rtl/bshift_count_decode.sv
module bshift_count_decode #(
  parameter int CW      = 5,
  parameter bit WRAP_EN = 1'b0,
  parameter int WRAP_AT = 32
) (
  input  logic [CW-1:0] count,
  input  logic          req_left,
  output logic          go_left,
  output logic          flipped,
  output logic [CW-1:0] mag
);
  localparam logic [CW-1:0] ONE    = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] WRAP_V = CW'(WRAP_AT);

  // Magnitude of a two's-complement count; the most negative value maps to 2**(CW-1).
  function automatic logic [CW-1:0] f_abs(input logic [CW-1:0] c);
    return c[CW-1] ? (~c + ONE) : c;
  endfunction

  logic [CW-1:0] raw_mag;

  assign flipped = count[CW-1];
  assign go_left = req_left ^ flipped;
  assign raw_mag = f_abs(count);

  generate
    if (WRAP_EN) begin : g_wrap
      assign mag = (raw_mag > WRAP_V) ? (raw_mag - WRAP_V) : raw_mag;
    end else begin : g_nowrap
      assign mag = raw_mag;
    end
  endgenerate
endmodule

// File: rtl/bshift_barrel.sv
module bshift_barrel #(
  parameter int W  = 16,
  parameter int MW = 5
) (
  input  logic [W-1:0]  data,
  input  logic [MW-1:0] mag,
  input  logic          go_left,
  output logic [W-1:0]  res,
  output logic          ovf
);
  // Left shift in a double-width field so that the lost bits stay visible.
  function automatic logic [2*W-1:0] f_shl(input logic [W-1:0] d, input logic [MW-1:0] m);
    logic [2*W-1:0] ext;
    ext = {{W{d[W-1]}}, d};
    return ext << m;
  endfunction

  function automatic logic [W-1:0] f_asr(input logic [W-1:0] d, input logic [MW-1:0] m);
    return W'($signed(d) >>> m);
  endfunction

  logic [2*W-1:0] wide;
  logic [W:0]     top;

  assign wide = f_shl(data, mag);
  assign top  = wide[2*W-1:W-1];
  assign res  = go_left ? wide[W-1:0] : f_asr(data, mag);
  assign ovf  = go_left & ~((&top) | ~(|top));
endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
  import bshift_pkg::*;
#(
  parameter int ACC_W   = bshift_pkg::ACC_W,
  parameter int HALF_W  = bshift_pkg::HALF_W,
  parameter int CNT_W   = bshift_pkg::CNT_W,
  parameter int HCNT_W  = bshift_pkg::HCNT_W,
  parameter int WRAP_AT = bshift_pkg::WRAP_AT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       in_op,
  input  logic [ACC_W-1:0] in_data,
  input  logic [CNT_W-1:0] in_count,
  output logic             out_valid,
  output logic [ACC_W-1:0] out_result,
  output logic             out_zero,
  output logic             out_ovf
);
  // Named internal events, brought out for the checker.
  logic              is_acc;
  logic              req_left;
  logic              h_go_left, h_flip;
  logic              a_go_left, a_flip;
  logic              eff_left;
  logic              flip_any;
  logic [HCNT_W-1:0] h_mag;
  logic [CNT_W-1:0]  a_mag;
  logic [HALF_W-1:0] h_res;
  logic [ACC_W-1:0]  a_res;
  logic              h_ovf, a_ovf;
  shres_t            nxt, cur;

  assign is_acc   = in_op[1];
  assign req_left = ~in_op[0];

  bshift_count_decode #(.CW(HCNT_W), .WRAP_EN(1'b0), .WRAP_AT(WRAP_AT)) u_hdec (
    .count   (in_count[HCNT_W-1:0]),
    .req_left(req_left),
    .go_left (h_go_left),
    .flipped (h_flip),
    .mag     (h_mag)
  );

  bshift_count_decode #(.CW(CNT_W), .WRAP_EN(1'b1), .WRAP_AT(WRAP_AT)) u_adec (
    .count   (in_count),
    .req_left(req_left),
    .go_left (a_go_left),
    .flipped (a_flip),
    .mag     (a_mag)
  );

  bshift_barrel #(.W(HALF_W), .MW(HCNT_W)) u_hbar (
    .data   (in_data[HALF_W-1:0]),
    .mag    (h_mag),
    .go_left(h_go_left),
    .res    (h_res),
    .ovf    (h_ovf)
  );

  bshift_barrel #(.W(ACC_W), .MW(CNT_W)) u_abar (
    .data   (in_data),
    .mag    (a_mag),
    .go_left(a_go_left),
    .res    (a_res),
    .ovf    (a_ovf)
  );

  assign eff_left = is_acc ? a_go_left : h_go_left;
  assign flip_any = is_acc ? a_flip : h_flip;

  always_comb begin
    nxt.result = is_acc ? a_res : {{(ACC_W-HALF_W){1'b0}}, h_res};
    nxt.ovf    = is_acc ? a_ovf : h_ovf;
    nxt.zero   = ~(|nxt.result);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) cur <= nxt;
    end
  end

  assign out_result = cur.result;
  assign out_zero   = cur.zero;
  assign out_ovf    = cur.ovf;
endmodule

// File: rtl/bshift_unit_chk.sv
module bshift_unit_chk #(
  parameter int ACC_W  = 40,
  parameter int HALF_W = 16,
  parameter int CNT_W  = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       in_op,
  input logic [ACC_W-1:0] in_data,
  input logic [CNT_W-1:0] in_count,
  input logic             out_valid,
  input logic [ACC_W-1:0] out_result,
  input logic             out_zero,
  input logic             out_ovf,
  input logic             eff_left,
  input logic             flip_any
);
  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0 && !out_zero && !out_ovf));

  p_valid_lat_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_zero) && $stable(out_ovf)));

  p_right_no_ovf_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !eff_left) |=> !out_ovf);

  p_zero_operand_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data == '0) |=> (out_zero && !out_ovf && out_result == '0));

  p_half_upper_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_op[1]) |=> (out_result[ACC_W-1:HALF_W] == '0));

  p_reverse_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_op[1] && in_count[4]) |-> (flip_any && eff_left == in_op[0]));

  p_direction_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[1]) |-> (eff_left == (in_op[0] == in_count[CNT_W-1])));
endmodule

bind bshift_unit bshift_unit_chk #(.ACC_W(ACC_W), .HALF_W(HALF_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_data(in_data),
  .in_count(in_count), .out_valid(out_valid), .out_result(out_result),
  .out_zero(out_zero), .out_ovf(out_ovf), .eff_left(eff_left), .flip_any(flip_any)
);

// File: tb/bshift_unit_bench.sv
module bshift_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'b00;
  logic [39:0] in_data = '0;
  logic [6:0]  in_count = '0;
  logic        out_valid;
  logic [39:0] out_result;
  logic        out_zero;
  logic        out_ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bshift_unit u_bshift_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_data(in_data),
    .in_count(in_count), .out_valid(out_valid), .out_result(out_result),
    .out_zero(out_zero), .out_ovf(out_ovf)
  );

  // Reference built from the requirements with 128-bit signed integers.
  task automatic model(input logic [1:0] op, input logic [39:0] d, input logic [6:0] cnt,
                       output logic [39:0] res, output logic z, output logic v);
    logic signed [127:0] full, back;
    int  c, m;
    bit  left, acc;
    acc  = op[1];
    left = !op[0];
    if (acc) c = int'($signed(cnt));
    else     c = int'($signed(cnt[4:0]));
    if (c < 0) begin left = !left; m = -c; end
    else m = c;
    if (acc && m > 32) m = m - 32;
    if (acc) full = {{88{d[39]}}, d};
    else     full = {{112{d[15]}}, d[15:0]};
    if (left) begin
      full = full <<< m;
      if (acc) back = {{88{full[39]}}, full[39:0]};
      else     back = {{112{full[15]}}, full[15:0]};
      v = (full != back);
    end else begin
      full = full >>> m;
      v = 1'b0;
    end
    res = acc ? full[39:0] : {24'b0, full[15:0]};
    z = (res == '0);
  endtask

  task automatic check(input string req, input string what, input logic [39:0] act,
                       input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One operation: drive at negedge, sample at the following negedge.
  task automatic run_op(input string req, input logic [1:0] op, input logic [39:0] d,
                        input logic [6:0] cnt);
    logic [39:0] er;
    logic ez, ev;
    model(op, d, cnt, er, ez, ev);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_data = d; in_count = cnt;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, "valid",  {39'b0, out_valid}, 40'd1);
    check(req, "result", out_result, er);
    check(req, "zero",   {39'b0, out_zero}, {39'b0, ez});
    check(req, "ovf",    {39'b0, out_ovf},  {39'b0, ev});
  endtask

  task automatic t_reset_r11();
    run_op("R2", 2'b00, 40'h0000004001, 7'd1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R11", "valid",  {39'b0, out_valid}, 40'd0);
    check("R11", "result", out_result, 40'd0);
    check("R11", "flags",  {38'b0, out_zero, out_ovf}, 40'd0);
  endtask

  task automatic t_half_in_range_r2();
    run_op("R2", 2'b00, 40'h0000000003, 7'd4);
    run_op("R2", 2'b01, 40'h0000008000, 7'd15);
    run_op("R6", 2'b01, 40'h0000004000, 7'd14);
    run_op("R2", 2'b00, 40'h000000ABCD, 7'd0);
    // Direct value: 0x8001 asr 1 fills with the sign bit.
    run_op("R6", 2'b01, 40'h0000008001, 7'd1);
    check("R6", "direct", out_result, 40'h000000C000);
  endtask

  task automatic t_half_reverse_r3();
    run_op("R3", 2'b00, 40'h0000008000, 7'h10);   // lsl by -16 -> asr by 16
    check("R3", "direct", out_result, 40'h000000FFFF);
    run_op("R3", 2'b00, 40'h0000001234, 7'h1F);   // lsl by -1 -> asr by 1
    check("R3", "direct", out_result, 40'h000000091A);
    run_op("R3", 2'b01, 40'h0000000001, 7'h10);   // asr by -16 -> lsl by 16
    check("R3", "zero_and_ovf", {38'b0, out_zero, out_ovf}, 40'd3);
    run_op("R3", 2'b01, 40'h0000000123, 7'h1C);   // asr by -4 -> lsl by 4
  endtask

  task automatic t_half_ignore_r9();
    run_op("R9", 2'b00, 40'hFFFFFF0021, 7'h62);   // count bits 6:5 and data 39:16 ignored
    check("R1", "direct", out_result, 40'h0000000084);
    run_op("R9", 2'b01, 40'hA5A5A5F000, 7'h24);
    check("R9", "direct", out_result, 40'h000000FF00);
  endtask

  task automatic t_acc_r4();
    run_op("R4", 2'b10, 40'h0000000001, 7'd31);
    run_op("R4", 2'b11, 40'h8000000000, 7'd20);
    run_op("R4", 2'b10, 40'hF000000000, 7'h7E);   // lsl by -2 -> asr by 2
    check("R4", "direct", out_result, 40'hFC00000000);
    run_op("R4", 2'b11, 40'h0000000005, 7'h7F);   // asr by -1 -> lsl by 1
    check("R4", "direct", out_result, 40'h000000000A);
  endtask

  task automatic t_acc_wrap_r5();
    run_op("R5", 2'b10, 40'h0000000001, 7'd40);   // 40 -> 8
    check("R5", "direct", out_result, 40'h0000000100);
    run_op("R5", 2'b10, 40'h0000000003, 7'd33);   // 33 -> 1
    run_op("R5", 2'b11, 40'h0000000100, 7'h40);   // asr by -64 -> lsl by 32
    check("R5", "zero_and_ovf", {38'b0, out_zero, out_ovf}, 40'd3);
    run_op("R5", 2'b11, 40'h0000000001, 7'h40);
    check("R5", "direct", out_result, 40'h0100000000);
    run_op("R5", 2'b11, 40'h8000000000, 7'd63);   // 63 -> 31
  endtask

  task automatic t_overflow_r7();
    run_op("R7", 2'b00, 40'h0000004000, 7'd1);
    check("R7", "direct", {39'b0, out_ovf}, 40'd1);
    run_op("R7", 2'b00, 40'h000000C000, 7'd1);
    check("R7", "direct", {39'b0, out_ovf}, 40'd0);
    run_op("R7", 2'b10, 40'h4000000000, 7'd1);
    run_op("R7", 2'b10, 40'hFFFFFFFFFF, 7'd32);
    run_op("R7", 2'b11, 40'h7FFFFFFFFF, 7'd5);
  endtask

  task automatic t_zero_r8();
    run_op("R8", 2'b01, 40'h0000000007, 7'd3);
    check("R8", "direct", {39'b0, out_zero}, 40'd1);
    run_op("R8", 2'b10, 40'h0000000000, 7'd9);
    run_op("R8", 2'b11, 40'h0000000001, 7'd1);
  endtask

  task automatic t_hold_r10();
    logic [39:0] keep;
    run_op("R10", 2'b10, 40'h0000001234, 7'd4);
    keep = out_result;
    @(negedge clk);
    in_op = 2'b01; in_data = 40'h0000000FFF; in_count = 7'd1;
    @(negedge clk);
    check("R10", "valid_low", {39'b0, out_valid}, 40'd0);
    check("R10", "held",      out_result, keep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "reset_valid", {39'b0, out_valid}, 40'd0);
    check("R11", "reset_result", out_result, 40'd0);
    rst = 1'b0;
    t_half_in_range_r2();
    t_half_reverse_r3();
    t_half_ignore_r9();
    t_acc_r4();
    t_acc_wrap_r5();
    t_overflow_r7();
    t_zero_r8();
    t_hold_r10();
    t_reset_r11();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule